// File: doc/BRIEF.md
# Serial Link Sideband Flag Mux

This block sits between a local parallel data port and the framer of a serial point-to-point link. It handles four single-bit sideband flags that ride in dedicated ordered-set slots next to the framed data. Two of the flags carry flow control and two are general-purpose I/O bits. Whenever the framer signals that a sideband slot is due, the block registers the four outbound values at once, so that every slot carries a consistent set. Which values it sends depends on a loop-mode bit and a receiver-disable bit.

On the inbound side, the decoder presents flag values with a valid strobe. The block keeps the last decoded set until the next strobe. In loop mode those held inbound values are relayed outward. The GPIO bits are passed straight through. Each flow-control bit is merged by OR with its local value while the receiver is enabled, and is taken from the link alone while the receiver is disabled.

Each local input can have a pulse stretcher. It keeps any assertion visible for at least the longest gap between two slots (521 clocks by default), so that even a one-cycle pulse is carried by at least one slot.

Top module: `sbflag_mux`

## Requirements
- R1: After a synchronous reset, `tx_flags_o` and `rx_flags_o` are both 4'b0000.
- R2: Flag positions on every 4-bit vector are fixed: bits [1:0] are the flow-control flags and bits [3:2] are the GPIO flags. With `loop_en`=0, a slot registers the stretched local inputs into `tx_flags_o`. The value appears on `tx_flags_o` one clock after the edge on which `slot_i` is high.
- R3: With `loop_en`=1, the GPIO bits [3:2] sent in a slot equal the held inbound bits [3:2], and local GPIO inputs have no effect.
- R4: With `loop_en`=1 and `rx_off`=0, each flow-control bit sent equals the held inbound bit ORed with the local bit.
- R5: With `loop_en`=1 and `rx_off`=1, each flow-control bit sent equals the held inbound bit, and local flow-control inputs have no effect.
- R6: `tx_flags_o` changes only on a clock edge where `slot_i` is high; between slots it holds its value whatever the local inputs do.
- R7: `rx_flags_o` loads `rx_flags_i` on each edge where `rx_valid_i` is high and otherwise holds. `rx_off` has no effect on it.
- R8: With the stretcher enabled, a local input high for the single edge t keeps its stretched value high for edges t through t+STRETCH_LEN-1. So a slot at edge t+520 sends it and a slot at edge t+521 does not (STRETCH_LEN=521).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_en | input | 1 | Loop mode: relay inbound flags outward (quasi-static) |
| rx_off | input | 1 | Receiver disabled (quasi-static) |
| loc_flags_i | input | 4 | Local parallel-port flag inputs |
| slot_i | input | 1 | Framer strobe: sideband slot is due |
| rx_flags_i | input | 4 | Flag values decoded from the link |
| rx_valid_i | input | 1 | Decoder strobe for `rx_flags_i` |
| tx_flags_o | output | 4 | Flag values for the current outbound slot |
| rx_flags_o | output | 4 | Last decoded inbound flag values |

## Verification
The bench goes through all three source choices for each flag class. It uses inbound and local patterns where the OR merge, link-only and local-only answers differ. A design that swapped the role of `rx_off`, or that merged the GPIO bits, would give a wrong bit in at least one vector. The stretcher is tested exactly at its boundary, with slots at edges t+520 and t+521 after a one-cycle pulse. An off-by-one counter would send the flag in the second slot or miss it in the first. Further tests check that the local inputs cannot leak into the output between slots, and that neither a missing valid strobe nor a toggle of `rx_off` changes the held inbound flags.

// File: rtl/sbflag_pkg.sv
package sbflag_pkg;
   localparam int unsigned SB_MAX_GAP = 521;

   typedef enum logic [1:0] {
      SRC_LOCAL = 2'd0,
      SRC_MERGE = 2'd1,
      SRC_LINK  = 2'd2
   } fc_src_e;
endpackage

// File: rtl/sbflag_stretch.sv
module sbflag_stretch #(
   parameter int unsigned LEN = 521
) (
   input  logic clk,
   input  logic rst,
   input  logic in_i,
   output logic out_o
);
   localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);

   if (LEN < 2) begin : g_bad_len
      $error("sbflag_stretch: LEN must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (in_i)
         cnt_q <= CW'(LEN - 1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign out_o = in_i | (cnt_q != '0);

   // R8: an input seen at one edge stays visible at the next
   a_r8_held_next: assert property (@(posedge clk) disable iff (rst)
      in_i |=> out_o);
   // R8: counter never loads above its limit
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      in_i |=> (cnt_q == CW'(LEN - 1)));
endmodule

// File: rtl/sbflag_rxhold.sv
module sbflag_rxhold #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] data_i,
   input  logic         valid_i,
   output logic [N-1:0] hold_o
);
   logic [N-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= '0;
      else if (valid_i)
         hold_q <= data_i;
   end

   assign hold_o = hold_q;

   a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(hold_o));
   a_r7_load: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> (hold_o == $past(data_i)));
endmodule

// File: rtl/sbflag_txsel.sv
module sbflag_txsel
   import sbflag_pkg::*;
#(
   parameter int unsigned NUM_FC   = 2,
   parameter int unsigned NUM_GPIO = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       loop_en,
   input  logic                       rx_off,
   input  logic                       slot_i,
   input  logic [NUM_FC+NUM_GPIO-1:0] loc_i,
   input  logic [NUM_FC+NUM_GPIO-1:0] link_i,
   output logic [NUM_FC+NUM_GPIO-1:0] tx_o
);
   localparam int unsigned N = NUM_FC + NUM_GPIO;

   fc_src_e      fc_src;
   logic [N-1:0] nxt;
   logic [N-1:0] tx_q;

   always_comb begin
      if (!loop_en)
         fc_src = SRC_LOCAL;
      else if (rx_off)
         fc_src = SRC_LINK;
      else
         fc_src = SRC_MERGE;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i < NUM_FC) begin : g_fc
         assign nxt[i] = (fc_src == SRC_LOCAL) ? loc_i[i] :
                         (fc_src == SRC_MERGE) ? (loc_i[i] | link_i[i]) :
                                                 link_i[i];
      end else begin : g_gpio
         assign nxt[i] = loop_en ? link_i[i] : loc_i[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         tx_q <= '0;
      else if (slot_i)
         tx_q <= nxt;
   end

   assign tx_o = tx_q;

   a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
      !slot_i |=> $stable(tx_o));
   a_r2_local: assert property (@(posedge clk) disable iff (rst)
      (slot_i && !loop_en) |=> (tx_o == $past(loc_i)));
   a_r3_gpio_relay: assert property (@(posedge clk) disable iff (rst)
      (slot_i && loop_en) |=> (tx_o[N-1:NUM_FC] == $past(link_i[N-1:NUM_FC])));
   a_r4_fc_merge: assert property (@(posedge clk) disable iff (rst)
      (slot_i && loop_en && !rx_off) |=>
         (tx_o[NUM_FC-1:0] == $past(link_i[NUM_FC-1:0] | loc_i[NUM_FC-1:0])));
   a_r5_fc_link: assert property (@(posedge clk) disable iff (rst)
      (slot_i && loop_en && rx_off) |=> (tx_o[NUM_FC-1:0] == $past(link_i[NUM_FC-1:0])));
endmodule

// File: rtl/sbflag_mux.sv
module sbflag_mux
   import sbflag_pkg::*;
#(
   parameter int unsigned NUM_FC      = 2,
   parameter int unsigned NUM_GPIO    = 2,
   parameter bit          STRETCH_EN  = 1'b1,
   parameter int unsigned STRETCH_LEN = SB_MAX_GAP
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       loop_en,
   input  logic                       rx_off,
   input  logic [NUM_FC+NUM_GPIO-1:0] loc_flags_i,
   input  logic                       slot_i,
   input  logic [NUM_FC+NUM_GPIO-1:0] rx_flags_i,
   input  logic                       rx_valid_i,
   output logic [NUM_FC+NUM_GPIO-1:0] tx_flags_o,
   output logic [NUM_FC+NUM_GPIO-1:0] rx_flags_o
);
   localparam int unsigned N = NUM_FC + NUM_GPIO;

   if (NUM_FC < 1 || NUM_GPIO < 1) begin : g_bad_counts
      $error("sbflag_mux: need at least one flag of each class");
   end

   logic [N-1:0] loc_s;
   logic [N-1:0] link_hold;

   if (STRETCH_EN) begin : g_stretch
      for (genvar i = 0; i < N; i++) begin : g_bit
         sbflag_stretch #(.LEN(STRETCH_LEN)) u_str (
            .clk   (clk),
            .rst   (rst),
            .in_i  (loc_flags_i[i]),
            .out_o (loc_s[i])
         );
      end
   end else begin : g_direct
      assign loc_s = loc_flags_i;
   end

   sbflag_rxhold #(.N(N)) u_rxhold (
      .clk     (clk),
      .rst     (rst),
      .data_i  (rx_flags_i),
      .valid_i (rx_valid_i),
      .hold_o  (link_hold)
   );

   sbflag_txsel #(.NUM_FC(NUM_FC), .NUM_GPIO(NUM_GPIO)) u_txsel (
      .clk     (clk),
      .rst     (rst),
      .loop_en (loop_en),
      .rx_off  (rx_off),
      .slot_i  (slot_i),
      .loc_i   (loc_s),
      .link_i  (link_hold),
      .tx_o    (tx_flags_o)
   );

   assign rx_flags_o = link_hold;

   // R7: inbound flags never move without a valid strobe, whatever rx_off does
   a_r7_port_hold: assert property (@(posedge clk) disable iff (rst)
      !rx_valid_i |=> $stable(rx_flags_o));
   // R2: a raw local assertion in a local-mode slot is always sent
   a_r2_raw_sent: assert property (@(posedge clk) disable iff (rst)
      (slot_i && !loop_en) |=> ((tx_flags_o & $past(loc_flags_i)) == $past(loc_flags_i)));
endmodule

// File: tb/sbflag_mux_bench.sv
module sbflag_mux_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       loop_en = 1'b0;
   logic       rx_off = 1'b0;
   logic [3:0] loc_flags_i = '0;
   logic       slot_i = 1'b0;
   logic [3:0] rx_flags_i = '0;
   logic       rx_valid_i = 1'b0;
   logic [3:0] tx_flags_o;
   logic [3:0] rx_flags_o;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sbflag_mux u_sbflag_mux (
      .clk         (clk),
      .rst         (rst),
      .loop_en     (loop_en),
      .rx_off      (rx_off),
      .loc_flags_i (loc_flags_i),
      .slot_i      (slot_i),
      .rx_flags_i  (rx_flags_i),
      .rx_valid_i  (rx_valid_i),
      .tx_flags_o  (tx_flags_o),
      .rx_flags_o  (rx_flags_o)
   );

   // {loop, rx_off, inbound[3:0], local[3:0], expected tx[3:0]}
   localparam logic [13:0] VEC [12] = '{
      {1'b0, 1'b0, 4'b1111, 4'b0000, 4'b0000},
      {1'b0, 1'b0, 4'b0000, 4'b1010, 4'b1010},
      {1'b0, 1'b1, 4'b1111, 4'b0101, 4'b0101},
      {1'b1, 1'b0, 4'b1100, 4'b0000, 4'b1100},
      {1'b1, 1'b0, 4'b0000, 4'b1100, 4'b0000},
      {1'b1, 1'b0, 4'b0001, 4'b0010, 4'b0011},
      {1'b1, 1'b0, 4'b0010, 4'b0010, 4'b0010},
      {1'b1, 1'b1, 4'b0001, 4'b0010, 4'b0001},
      {1'b1, 1'b1, 4'b1010, 4'b0111, 4'b1010},
      {1'b1, 1'b0, 4'b0110, 4'b1101, 4'b0111},
      {1'b1, 1'b1, 4'b0000, 4'b1111, 4'b0000},
      {1'b1, 1'b0, 4'b1001, 4'b0110, 4'b1011}
   };

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic load_rx(input logic [3:0] v);
      rx_flags_i = v; rx_valid_i = 1'b1;
      @(negedge clk);
      rx_valid_i = 1'b0;
   endtask

   task automatic fire_slot;
      slot_i = 1'b1;
      @(negedge clk);
      slot_i = 1'b0;
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 tx reset", tx_flags_o, 4'b0000);
      chk("R1 rx reset", rx_flags_o, 4'b0000);

      // R2 R3 R4 R5 R7: vector table
      for (int i = 0; i < 12; i++) begin
         loc_flags_i = '0;
         idle(530);
         load_rx(VEC[i][11:8]);
         loop_en = VEC[i][13];
         rx_off = VEC[i][12];
         loc_flags_i = VEC[i][7:4];
         fire_slot();
         loc_flags_i = '0;
         chk($sformatf("R2-5 vector %0d tx", i), tx_flags_o, VEC[i][3:0]);
         chk($sformatf("R7 vector %0d rx", i), rx_flags_o, VEC[i][11:8]);
      end

      // R6: local changes between slots leave tx untouched
      loop_en = 1'b0; rx_off = 1'b0;
      idle(530);
      loc_flags_i = 4'b0110;
      fire_slot();
      loc_flags_i = 4'b1001;
      idle(4);
      chk("R6 hold between slots", tx_flags_o, 4'b0110);
      fire_slot();
      chk("R6 next slot updates", tx_flags_o, 4'b1111);
      loc_flags_i = '0;

      // R7: no strobe and rx_off toggling keep inbound flags
      load_rx(4'b0101);
      rx_flags_i = 4'b1010;
      rx_off = 1'b1;
      idle(3);
      rx_off = 1'b0;
      idle(2);
      chk("R7 hold without strobe", rx_flags_o, 4'b0101);

      // R8: one-cycle pulse seen at edge t+520
      loop_en = 1'b0;
      idle(530);
      fire_slot();
      chk("R8 cleared before pulse", tx_flags_o, 4'b0000);
      loc_flags_i = 4'b0001;
      @(negedge clk);
      loc_flags_i = 4'b0000;
      idle(519);
      fire_slot();
      chk("R8 slot at t+520 sends pulse", tx_flags_o, 4'b0001);

      // R8: same pulse not seen at edge t+521
      idle(530);
      fire_slot();
      loc_flags_i = 4'b0001;
      @(negedge clk);
      loc_flags_i = 4'b0000;
      idle(520);
      fire_slot();
      chk("R8 slot at t+521 drops pulse", tx_flags_o, 4'b0000);

      // R1: reset again clears both sides
      load_rx(4'b1111);
      loc_flags_i = 4'b1111;
      fire_slot();
      loc_flags_i = '0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 tx re-reset", tx_flags_o, 4'b0000);
      chk("R1 rx re-reset", rx_flags_o, 4'b0000);

      finish_run();
   end
endmodule